// File: doc/BRIEF.md
# Interrupt CPU-Target Register Bank

This block stores which CPUs each interrupt of a distributor may be delivered to. Every interrupt owns one 8-bit target mask, and there is one bit per CPU. Software reaches the masks through a request/response register port. Each request carries a byte offset into the target window and is either a single-byte access or a 32-bit access. A 32-bit access reaches four neighbouring interrupts at once.

The bank has a `cpu_count` input that gives the number of CPUs present. Any written mask is cut down to those CPUs before it is stored. The lowest 32 interrupts are private to each CPU, so software cannot change their targets. The bank drives every stored mask to the delivery logic in parallel. Beside each mask it drives one routed CPU index, taken from the lowest set bit of that mask.

Requests use a valid/ready handshake. Each accepted request produces exactly one response, and responses come back in request order. A new request is taken only when no response is waiting or when the waiting response is consumed in the same cycle. While `rsp_ready` is low, a pending response stays unchanged and new requests are held off.

Top module: `irq_target_bank`

## Requirements
- R1: After reset every target mask is 0x00, every routed index is 0, and `rsp_valid` is low.
- R2: A word access (`req_size`=1) uses base = `req_addr` with its two low bits cleared. Byte lane k (bits 8k+7..8k) belongs to interrupt base+k, for k = 0..3.
- R3: A byte access (`req_size`=0) reaches only interrupt `req_addr`. The write data is taken from bits 7..0, and all other masks are left unchanged.
- R4: Writes to interrupts 0 to 31 have no effect, and those masks read back as 0x00.
- R5: A written byte is ANDed with a mask whose low `cpu_count` bits are ones. A `cpu_count` of 8 or more keeps all 8 bits.
- R6: The routed index of an interrupt is the bit position of the lowest set bit of its mask, or 0 if the mask is zero. The new mask and index are visible in the cycle after the write is accepted.
- R7: A read response carries the stored masks in their byte lanes. A byte read returns its mask in bits 7..0 and zero in bits 31..8.
- R8: Interrupt numbers at or above `NUM_IRQ` read as zero, and writes to them are ignored.
- R9: Each accepted request produces exactly one response, one cycle later and in order. A write response carries zero data. A response is held stable while `rsp_ready` is low, and `req_ready` = !`rsp_valid` || `rsp_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_count | input | 4 | Number of CPUs present |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The bank can take the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 1 | 0 = byte access, 1 = word access |
| req_addr | input | $clog2(NUM_IRQ)+1 | Byte offset in the target window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | A response is available |
| rsp_ready | input | 1 | The consumer accepts the response |
| rsp_rdata | output | 32 | Read data, or zero for a write |
| tgt_mask | output | NUM_IRQ*8 | Stored mask of interrupt i at bits 8i+7..8i |
| route_cpu | output | NUM_IRQ*3 | Routed CPU index of interrupt i at bits 3i+2..3i |

## Verification
Assertions check four rules on every cycle:
- each routed index points at the lowest set bit of its mask;
- a freshly written mask has no bits above the CPU count that applied at the write;
- private masks stay zero;
- a stalled response holds its data while `req_ready` stays low.

Lane placement, word-base alignment, out-of-range addresses and the read data itself can only be shown by the bench's scenarios. The bench compares every response against a reference model, and the responses arrive while the consumer applies back-pressure.

// File: rtl/irq_target_pkg.sv
package irq_target_pkg;
  localparam int TGT_W  = 8;
  localparam int CPU_W  = 3;
  localparam int LANES  = 4;
  localparam int DATA_W = TGT_W * LANES;

  typedef enum logic {
    ACC_BYTE = 1'b0,
    ACC_WORD = 1'b1
  } acc_size_e;

  function automatic logic [TGT_W-1:0] cpu_keep_mask(input logic [3:0] count);
    logic [TGT_W-1:0] m;
    for (int b = 0; b < TGT_W; b++) m[b] = (count > 4'(b));
    return m;
  endfunction
endpackage

// File: rtl/irq_target_wrdec.sv
module irq_target_wrdec
  import irq_target_pkg::*;
#(
  parameter int NUM_IRQ  = 64,
  parameter int PRIV_IRQ = 32,
  parameter int ADDR_W   = 7
) (
  input  logic                     wr_fire,
  input  logic                     size,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [3:0]               cpu_count,
  output logic [NUM_IRQ-1:0]       wr_en,
  output logic [NUM_IRQ*TGT_W-1:0] wr_byte
);
  logic [TGT_W-1:0] keep;
  assign keep = cpu_keep_mask(cpu_count);

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
    if (i < PRIV_IRQ) begin : g_priv
      assign wr_en[i]                 = 1'b0;
      assign wr_byte[i*TGT_W +: TGT_W] = '0;
    end else begin : g_shared
      localparam logic [ADDR_W-1:0] IA = ADDR_W'(i);
      localparam int LANE = i % LANES;
      logic hit;
      logic [TGT_W-1:0] raw;
      assign hit = (size == ACC_WORD) ? (addr[ADDR_W-1:2] == IA[ADDR_W-1:2])
                                      : (addr == IA);
      assign raw = (size == ACC_WORD) ? wdata[LANE*TGT_W +: TGT_W]
                                      : wdata[TGT_W-1:0];
      assign wr_en[i]                 = wr_fire & hit;
      assign wr_byte[i*TGT_W +: TGT_W] = raw & keep;
    end
  end
endmodule

// File: rtl/irq_target_entry.sv
module irq_target_entry
  import irq_target_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [TGT_W-1:0] wr_byte,
  output logic [TGT_W-1:0] mask_q,
  output logic [CPU_W-1:0] route
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mask_q <= '0;
    else if (wr_en) mask_q <= wr_byte;
  end

  always_comb begin
    route = '0;
    for (int b = TGT_W - 1; b >= 0; b--)
      if (mask_q[b]) route = CPU_W'(b);
  end

  // R6: index names a set bit and nothing lower is set
  assert_route_lowest_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q != '0) |-> (mask_q[route] && ((mask_q & ((TGT_W'(1) << route) - TGT_W'(1))) == '0)));
  assert_route_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> (route == '0));
endmodule

// File: rtl/irq_target_bank.sv
module irq_target_bank
  import irq_target_pkg::*;
#(
  parameter int NUM_IRQ  = 64,
  parameter int PRIV_IRQ = 32,
  localparam int IDX_W   = $clog2(NUM_IRQ),
  localparam int ADDR_W  = IDX_W + 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [3:0]                 cpu_count,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic                       req_write,
  input  logic                       req_size,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [31:0]                req_wdata,
  output logic                       rsp_valid,
  input  logic                       rsp_ready,
  output logic [31:0]                rsp_rdata,
  output logic [NUM_IRQ*TGT_W-1:0]   tgt_mask,
  output logic [NUM_IRQ*CPU_W-1:0]   route_cpu
);
  logic                       accept;
  logic [NUM_IRQ-1:0]         wr_en;
  logic [NUM_IRQ*TGT_W-1:0]   wr_byte;
  logic [TGT_W-1:0]           masks [NUM_IRQ];
  logic [DATA_W-1:0]          rd_gather;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  irq_target_wrdec #(
    .NUM_IRQ (NUM_IRQ),
    .PRIV_IRQ(PRIV_IRQ),
    .ADDR_W  (ADDR_W)
  ) u_wrdec (
    .wr_fire  (accept && req_write),
    .size     (req_size),
    .addr     (req_addr),
    .wdata    (req_wdata),
    .cpu_count(cpu_count),
    .wr_en    (wr_en),
    .wr_byte  (wr_byte)
  );

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_ent
    irq_target_entry u_ent (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en[i]),
      .wr_byte(wr_byte[i*TGT_W +: TGT_W]),
      .mask_q (masks[i]),
      .route  (route_cpu[i*CPU_W +: CPU_W])
    );
    assign tgt_mask[i*TGT_W +: TGT_W] = masks[i];

    // R5: stored bits never exceed the CPU count in force at the write
    assert_trim_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en[i] |=> ((masks[i] & ~$past(cpu_keep_mask(cpu_count))) == '0));

    if (i < PRIV_IRQ) begin : g_priv_chk
      assert_private_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        masks[i] == '0);
    end
  end

  always_comb begin
    logic [ADDR_W-1:0] idx;
    rd_gather = '0;
    for (int k = 0; k < LANES; k++) begin
      idx = (req_size == ACC_WORD) ? {req_addr[ADDR_W-1:2], 2'(k)} : req_addr;
      if ((req_size == ACC_WORD || k == 0) && (int'(idx) < NUM_IRQ))
        rd_gather[k*TGT_W +: TGT_W] = masks[idx[IDX_W-1:0]];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= req_write ? '0 : rd_gather;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R9: back-pressure holds the response and blocks new requests
  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
  assert_stall_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
endmodule

// File: tb/irq_target_bank_test.sv
module irq_target_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int NIRQ = 64;
  localparam int AW = 7;

  logic clk = 0, rst_n = 0;
  logic [3:0] cpu_count = 4'd8;
  logic req_valid = 0, req_write = 0, req_size = 0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_ready;
  logic [31:0] rsp_rdata;
  logic [NIRQ*8-1:0] tgt_mask;
  logic [NIRQ*3-1:0] route_cpu;

  int checks = 0, failures = 0;
  logic [7:0] model [NIRQ];
  logic [31:0] expq [$];
  logic stall = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  irq_target_bank uut (
    .clk(clk), .rst_n(rst_n), .cpu_count(cpu_count),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .tgt_mask(tgt_mask), .route_cpu(route_cpu)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] low_bit(input logic [7:0] m);
    for (int b = 0; b < 8; b++) if (m[b]) return 3'(b);
    return 3'd0;
  endfunction

  function automatic logic [7:0] keep(input logic [3:0] n);
    return (n >= 8) ? 8'hFF : 8'((9'd1 << n) - 9'd1);
  endfunction

  function automatic logic [31:0] model_read(input logic sz, input logic [AW-1:0] a);
    logic [31:0] r = '0;
    if (sz) begin
      for (int k = 0; k < 4; k++) begin
        int ix = (int'(a) & ~3) + k;
        if (ix < NIRQ) r[k*8 +: 8] = model[ix];
      end
    end else if (int'(a) < NIRQ) r[7:0] = model[a];
    return r;
  endfunction

  task automatic model_write(input logic sz, input logic [AW-1:0] a, input logic [31:0] d);
    if (sz) begin
      for (int k = 0; k < 4; k++) begin
        int ix = (int'(a) & ~3) + k;
        if (ix >= 32 && ix < NIRQ) model[ix] = d[k*8 +: 8] & keep(cpu_count);
      end
    end else if (int'(a) >= 32 && int'(a) < NIRQ) model[a] = d[7:0] & keep(cpu_count);
  endtask

  // driver: pushes the expected response, then offers the request
  task automatic do_req(input logic wr, input logic sz, input logic [AW-1:0] a, input logic [31:0] d);
    expq.push_back(wr ? 32'h0 : model_read(sz, a));
    @(negedge clk); #1;
    req_valid = 1; req_write = wr; req_size = sz; req_addr = a; req_wdata = d;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk); #1;
    req_valid = 0;
    if (wr) model_write(sz, a, d);
  endtask

  // monitor: pops and compares each response as it is consumed (R9, R7)
  initial begin
    rsp_ready = 1;
    forever begin
      @(negedge clk);
      rsp_ready = !stall || (cyc % 3 == 0);
      if (rsp_valid && rsp_ready) begin
        if (expq.size() == 0) chk("R9 unexpected response", rsp_rdata, 32'hx);
        else chk("R9/R7 response data", rsp_rdata, expq.pop_front());
      end
    end
  end

  task automatic drain;
    int n = 0;
    while (expq.size() != 0 && n < 100) begin @(negedge clk); n++; end
    #2;
    chk("R9 all responses returned", expq.size(), 0);
  endtask

  task automatic check_all(input string tag);
    for (int i = 0; i < NIRQ; i++) begin
      chk({tag, " mask"}, tgt_mask[i*8 +: 8], model[i]);
      chk("R6 route", route_cpu[i*3 +: 3], low_bit(model[i]));
    end
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NIRQ; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rsp_valid after reset", rsp_valid, 0);
    chk("R1 masks after reset", (tgt_mask == '0), 1);
    chk("R1 routes after reset", (route_cpu == '0), 1);
    rst_n = 1;
    @(negedge clk);

    // R2 word write, lanes to base+k; R6 routes
    cpu_count = 4'd8;
    do_req(1, 1, 7'd32, 32'h80040C01);
    chk("R2 irq32", tgt_mask[32*8 +: 8], 8'h01);
    chk("R2 irq33", tgt_mask[33*8 +: 8], 8'h0C);
    chk("R2 irq35", tgt_mask[35*8 +: 8], 8'h80);
    chk("R6 route irq33", route_cpu[33*3 +: 3], 3'd2);
    chk("R6 route irq35", route_cpu[35*3 +: 3], 3'd7);
    // R2 unaligned word read uses cleared base
    do_req(0, 1, 7'd35, 32'h0);

    // R3 byte write, R5 trimming to 4 CPUs
    cpu_count = 4'd4;
    do_req(1, 0, 7'd41, 32'hFFFFFFF6);
    chk("R5 irq41 trimmed", tgt_mask[41*8 +: 8], 8'h06);
    chk("R6 route irq41", route_cpu[41*3 +: 3], 3'd1);
    chk("R3 irq40 untouched", tgt_mask[40*8 +: 8], 8'h00);
    chk("R3 irq42 untouched", tgt_mask[42*8 +: 8], 8'h00);
    do_req(0, 0, 7'd41, 32'h0);   // R7 byte read
    do_req(0, 0, 7'd35, 32'h0);

    // R4 private writes ignored
    cpu_count = 4'd8;
    do_req(1, 1, 7'd4, 32'hFFFFFFFF);
    do_req(1, 0, 7'd31, 32'hFF);
    chk("R4 irq4", tgt_mask[4*8 +: 8], 8'h00);
    chk("R4 irq31", tgt_mask[31*8 +: 8], 8'h00);
    do_req(0, 1, 7'd4, 32'h0);

    // R6 zero mask falls back to 0
    do_req(1, 0, 7'd33, 32'h0);
    chk("R6 zero mask route", route_cpu[33*3 +: 3], 3'd0);

    // R5 single and two CPUs
    cpu_count = 4'd1;
    do_req(1, 1, 7'd60, 32'hFFFFFFFF);
    chk("R5 one cpu irq63", tgt_mask[63*8 +: 8], 8'h01);
    cpu_count = 4'd2;
    do_req(1, 0, 7'd61, 32'h000000FE);
    chk("R5 two cpus irq61", tgt_mask[61*8 +: 8], 8'h02);
    chk("R6 route irq61", route_cpu[61*3 +: 3], 3'd1);

    // R8 beyond configured count
    cpu_count = 4'd8;
    do_req(1, 1, 7'd64, 32'hFFFFFFFF);
    do_req(1, 0, 7'd127, 32'hFF);
    do_req(0, 1, 7'd64, 32'h0);
    do_req(0, 0, 7'd127, 32'h0);
    drain();
    check_all("R8 after out-of-range");

    // R9 back-pressure with mixed traffic
    stall = 1;
    do_req(1, 1, 7'd48, 32'h10203040);
    do_req(0, 1, 7'd48, 32'h0);
    do_req(0, 0, 7'd50, 32'h0);
    do_req(0, 1, 7'd32, 32'h0);
    do_req(1, 0, 7'd49, 32'h000000A0);
    do_req(0, 1, 7'd51, 32'h0);
    stall = 0;
    drain();
    check_all("R2 final");
    finish_run();
  end
endmodule